// File: doc/BRIEF.md
# SONET Line AIS Inserter with Selectable B2

This block sits on the byte-wide receive path, downstream of the framer. Each byte arrives with position strobes. The strobes give the frame start, the STS-1 the byte belongs to, and whether the byte lies in the transport overhead, with its row and column there.

The block has three modes:

- **Normal mode:** it retransmits the stream and rewrites the B2 byte of every STS-1 with a freshly computed BIP-8.
- **Alarm mode:** it keeps the section overhead and forces the line overhead and payload to all ones. This forms a line alarm indication signal. In this mode the B2 of the first STS-1 carries either a computed BIP-8 or a constant 0xFF, chosen by a control bit.
- **Bypass mode:** every byte passes untouched. Bypass outranks alarm mode.

All three control inputs are captured on the frame-start byte. A mode change therefore never splits a frame.

Top module: `sonet_ais_inserter`

## Requirements
- R1: Output lags input by one clock. `out_valid` and `out_fstart` repeat `in_valid` and (`in_valid` and `in_fstart`) one cycle later. After reset, `out_valid`, `out_fstart` and `out_data` are all 0.
- R2: A section-overhead byte (`in_toh`=1 with `in_row` 1 to 3) is emitted unchanged in every mode.
- R3: In normal mode, every line-overhead or payload byte that is not a B2 position is emitted unchanged.
- R4: The B2 position is `in_toh`=1, `in_row`=5, `in_tcol`=0. In normal mode the B2 byte of STS-1 index k (`in_sts`=k) is replaced by the even-parity BIP-8 of all bytes the block emitted for STS-1 k in the previous frame. That set includes the B2 byte and excludes TOH rows 1 to 3. In the first frame after reset this value is 0x00.
- R5: In alarm mode, every line-overhead and payload byte is emitted as 0xFF, except the B2 of STS-1 index 0.
- R6: In alarm mode with `b2_calc`=1, the B2 of STS-1 index 0 carries the BIP-8 defined in R4.
- R7: In alarm mode with `b2_calc`=0, the B2 of STS-1 index 0 is 0xFF.
- R8: With `pass_thru`=1, every byte is emitted unchanged, B2 included, whatever `ais_en` is.
- R9: `ais_en`, `b2_calc` and `pass_thru` take effect only on a valid frame-start byte. They apply from that byte to the end of the frame, and changing them mid-frame has no effect.
- R10: A cycle with `in_valid`=0 produces `out_valid`=0 one cycle later. That cycle leaves `out_data`, the BIP-8 state and the captured modes unchanged, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Input byte valid |
| in_fstart | input | 1 | First byte of frame |
| in_data | input | 8 | Input byte |
| in_sts | input | SW | STS-1 index, 0 is the first |
| in_row | input | 4 | Overhead row 1 to 9 |
| in_toh | input | 1 | Byte lies in transport overhead |
| in_tcol | input | 2 | Overhead column 0 to 2 |
| ais_en | input | 1 | Alarm insertion request |
| b2_calc | input | 1 | Compute first-STS B2 during alarm |
| pass_thru | input | 1 | Bypass all modification |
| out_valid | output | 1 | Output byte valid |
| out_fstart | output | 1 | Output frame start |
| out_data | output | 8 | Output byte |

## Verification
Every result is one register away from its stimulus. A byte presented before a rising edge shows up on the outputs just after that edge. The bench drives on the falling edge and compares one time unit after the next rising edge, for data and strobes alike. The B2 expectations come from the bench's own parity accumulators, fed with the bytes it predicted for the previous frame. A B2 check therefore depends on a whole earlier frame being right. Mid-frame control flips and idle cycles carrying junk strobes show that R9 and R10 hold at the outputs, on the same one-cycle schedule.

// File: rtl/sonet_ais_inserter.sv
module sonet_ais_inserter #(
  parameter int NUM_STS = 3,
  localparam int SW = (NUM_STS > 1) ? $clog2(NUM_STS) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_fstart,
  input  logic [7:0]    in_data,
  input  logic [SW-1:0] in_sts,
  input  logic [3:0]    in_row,
  input  logic          in_toh,
  input  logic [1:0]    in_tcol,
  input  logic          ais_en,
  input  logic          b2_calc,
  input  logic          pass_thru,
  output logic          out_valid,
  output logic          out_fstart,
  output logic [7:0]    out_data
);

  logic ais_q, b2c_q, pt_q;
  logic [7:0] acc [NUM_STS];
  logic [7:0] bip [NUM_STS];
  logic [7:0] nxt, bip_sel;

  wire fs     = in_valid && in_fstart;
  wire ais_m  = fs ? ais_en    : ais_q;
  wire b2c_m  = fs ? b2_calc   : b2c_q;
  wire pt_m   = fs ? pass_thru : pt_q;
  wire is_soh = in_toh && (in_row <= 4'd3);
  wire is_b2  = in_toh && (in_row == 4'd5) && (in_tcol == 2'd0);
  wire sts_ok = (32'(in_sts) < NUM_STS);
  wire first  = (in_sts == '0);

  always_comb begin
    bip_sel = in_data;
    for (int i = 0; i < NUM_STS; i++)
      if (32'(in_sts) == i) bip_sel = bip[i];
  end

  always_comb begin
    if (pt_m || is_soh)
      nxt = in_data;
    else if (ais_m)
      nxt = (is_b2 && first && b2c_m) ? bip[0] : 8'hFF;
    else if (is_b2 && sts_ok)
      nxt = bip_sel;
    else
      nxt = in_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ais_q <= 1'b0;
      b2c_q <= 1'b0;
      pt_q  <= 1'b0;
    end else if (fs) begin
      ais_q <= ais_en;
      b2c_q <= b2_calc;
      pt_q  <= pass_thru;
    end
  end

  for (genvar g = 0; g < NUM_STS; g++) begin : g_bip
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        acc[g] <= 8'h00;
        bip[g] <= 8'h00;
      end else if (fs) begin
        bip[g] <= acc[g];
        acc[g] <= 8'h00;
      end else if (in_valid && !is_soh && (in_sts == SW'(g))) begin
        acc[g] <= acc[g] ^ nxt;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid  <= 1'b0;
      out_fstart <= 1'b0;
      out_data   <= 8'h00;
    end else begin
      out_valid  <= in_valid;
      out_fstart <= fs;
      if (in_valid) out_data <= nxt;
    end
  end

  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid && (out_fstart == $past(in_fstart))); // R1
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && $stable(out_data)); // R10
  AST_SOH_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_soh) |=> out_data == $past(in_data)); // R2
  AST_BYPASS: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pt_m) |=> out_data == $past(in_data)); // R8
  AST_AIS_ONES: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pt_m && ais_m && !is_soh && !(is_b2 && first)) |=> out_data == 8'hFF); // R5
  AST_B2_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !pt_m && ais_m && !b2c_m && is_b2 && first) |=> out_data == 8'hFF); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !fs |=> $stable({ais_q, b2c_q, pt_q})); // R9

endmodule

// File: tb/tb_sonet_ais_inserter.sv
module tb_sonet_ais_inserter;
  localparam int NS = 3;
  localparam int PC = 2;
  localparam int NV = 10;
  // fields: [4] ais, [3] b2 calc, [2] bypass, [1] mid-frame flip, [0] idle gaps
  localparam logic [4:0] VEC [NV] = '{
    5'b00000, 5'b00000, 5'b11000, 5'b11000, 5'b10000,
    5'b10100, 5'b00010, 5'b11010, 5'b00001, 5'b11001};

  logic clk = 0, rst_n = 0;
  logic in_valid = 0, in_fstart = 0, in_toh = 0;
  logic [7:0] in_data = 0;
  logic [1:0] in_sts = 0, in_tcol = 0;
  logic [3:0] in_row = 0;
  logic ais_en = 0, b2_calc = 0, pass_thru = 0;
  logic out_valid, out_fstart;
  logic [7:0] out_data;

  int checks = 0, fails = 0;
  logic [7:0] m_acc [NS];
  logic [7:0] m_bip [NS];
  logic m_ais = 0, m_b2c = 0, m_pt = 0;
  logic [7:0] last_out = 0;
  bit flip_frame = 0;

  always #4 clk = ~clk;

  sonet_ais_inserter #(.NUM_STS(NS)) dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < NS; i++) begin m_acc[i] = 0; m_bip[i] = 0; end
    m_ais = 0; m_b2c = 0; m_pt = 0; last_out = 0;
  endtask

  task automatic drive_byte(input logic [7:0] d, input bit fs, input int s, input int row,
                            input bit toh, input int tc);
    logic [7:0] exp;
    string tag;
    bit soh, b2;
    if (fs) begin
      m_ais = ais_en; m_b2c = b2_calc; m_pt = pass_thru;
      for (int i = 0; i < NS; i++) begin m_bip[i] = m_acc[i]; m_acc[i] = 0; end
    end
    soh = toh && row <= 3;
    b2 = toh && row == 5 && tc == 0;
    if (soh) begin exp = d; tag = "R2"; end
    else if (m_pt) begin exp = d; tag = "R8"; end
    else if (m_ais) begin
      if (b2 && s == 0) begin exp = m_b2c ? m_bip[0] : 8'hFF; tag = m_b2c ? "R6" : "R7"; end
      else begin exp = 8'hFF; tag = "R5"; end
    end
    else if (b2) begin exp = m_bip[s]; tag = "R4"; end
    else begin exp = d; tag = "R3"; end
    if (flip_frame) tag = {tag, "/R9"};
    if (!soh) m_acc[s] ^= exp;
    @(negedge clk);
    in_valid = 1; in_data = d; in_fstart = fs; in_sts = 2'(s);
    in_row = 4'(row); in_toh = toh; in_tcol = 2'(tc);
    @(posedge clk); #1;
    chk(out_valid == 1'b1 && out_fstart == fs, "R1", {6'd0, out_valid, out_fstart}, {6'd0, 1'b1, fs});
    chk(out_data == exp, tag, out_data, exp);
    last_out = exp;
  endtask

  task automatic idle();
    @(negedge clk);
    in_valid = 0; in_data = 8'h5A; in_fstart = 1; in_row = 4'd5; in_toh = 1; in_tcol = 0;
    in_sts = 0; ais_en = ~ais_en; b2_calc = ~b2_calc;
    @(posedge clk); #1;
    chk(out_valid == 1'b0 && out_data == last_out, "R10", out_data, last_out);
  endtask

  task automatic send_frame(input int fr, input bit flip, input bit gap);
    flip_frame = flip;
    for (int row = 1; row <= 9; row++) begin
      for (int tc = 0; tc < 3; tc++)
        for (int s = 0; s < NS; s++) begin
          if (flip && row == 3 && tc == 0 && s == 0) begin
            ais_en = ~ais_en; b2_calc = ~b2_calc; pass_thru = ~pass_thru;
          end
          if (gap && tc == 1 && s == 0) idle();
          drive_byte(8'((fr * 37 + row * 11 + tc * 5 + s * 3 + 1)),
                     row == 1 && tc == 0 && s == 0, s, row, 1'b1, tc);
        end
      for (int pc = 0; pc < PC; pc++)
        for (int s = 0; s < NS; s++)
          drive_byte(8'((fr * 53 + row * 7 + pc * 13 + s * 19 + 2)), 1'b0, s, row, 1'b0, 0);
    end
    flip_frame = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R1 actual=hung expected=done");
    report();
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #1;
    chk(out_valid == 0 && out_fstart == 0 && out_data == 0, "R1 reset", out_data, 8'h00);
    @(negedge clk); rst_n = 1;
    for (int v = 0; v < NV; v++) begin
      ais_en = VEC[v][4]; b2_calc = VEC[v][3]; pass_thru = VEC[v][2];
      send_frame(v, VEC[v][1], VEC[v][0]);
    end
    // directed: reset mid-stream clears outputs and BIP state
    @(negedge clk); in_valid = 0; rst_n = 0;
    #1;
    chk(out_valid == 0 && out_fstart == 0 && out_data == 0, "R1 reset", out_data, 8'h00);
    model_clear();
    @(negedge clk); rst_n = 1;
    ais_en = 0; b2_calc = 0; pass_thru = 0;
    send_frame(20, 1'b0, 1'b0);
    // directed: alarm with computed B2 after a normal frame, then bypass over alarm
    ais_en = 1; b2_calc = 1;
    send_frame(21, 1'b0, 1'b0);
    pass_thru = 1;
    send_frame(22, 1'b0, 1'b1);
    pass_thru = 0; ais_en = 0;
    send_frame(23, 1'b0, 1'b0);
    @(negedge clk); in_valid = 0;
    report();
  end
endmodule